// File: doc/BRIEF.md
# Serial Master Interrupt Status Unit

This block gathers the interrupt causes of a serial port that works either as an SPI master or as an I2C master. The shift engines and the receive data buffer send it single-cycle strobes: a byte loaded into the buffer, the buffer read by the CPU, and an I2C operation finished together with a 3-bit code that names what finished. From these strobes the unit keeps sticky cause flags. It also tracks whether the receive buffer holds unread data, so that it can detect overrun. It records the cause of the latest finished I2C operation as a status code.

Each cause has its own enable bit. A mode input picks which group of causes, SPI or I2C, may drive the single interrupt request line to the interrupt controller. A small register port lets the CPU write the enables, clear flags by writing ones, write the status code, and read all three back through a combinational read path.

Register map (two address bits):

| Address | Contents | Access |
|---|---|---|
| 0 | Cause enables | read/write |
| 1 | Cause flags | read, write 1 to clear |
| 2 | I2C status code in bits [2:0] | read/write |
| 3 | Reads as zero | — |

The enable and flag registers use the same bit positions:

| Bit | Cause |
|---|---|
| 0 | SPI buffer full |
| 1 | SPI receive error |
| 2 | I2C operation done |
| 3 | I2C receive error |

Unused read bits return 0.

Top module: `sm_irq_unit`

## Requirements
- R1: After reset the enable register, the flag register and the status code all read 0, and `irq` is 0.
- R2: With `mode_i2c`=0, an `rx_load` strobe sets flag bit 0 (SPI buffer full). The flag reads 1 from the next clock edge on.
- R3: An `rx_load` while the buffer holds unread data, with no `rx_read` in the same cycle, is an overrun. An overrun sets flag bit 1 when `mode_i2c`=0 and flag bit 3 when `mode_i2c`=1.
- R4: An `rx_read` strobe marks the buffer empty, so the next `rx_load` is not an overrun. An `rx_load` together with an `rx_read` in the same cycle is not an overrun either.
- R5: With `mode_i2c`=1, an `op_done` strobe sets flag bit 2. For any `op_code` from 0 to 6, it also loads that code into the status register. The codes mean: 0 start sent, 1 stop sent, 2 transmit buffer empty, 3 receive buffer full, 4 ACK/NAK sent, 5 ACK received, 6 NAK received.
- R6: An `op_done` with the reserved code 7 still sets flag bit 2, but it leaves the status code unchanged. Events therefore never produce the value 7.
- R7: A flag is set whether or not its enable is 1. `irq` is the OR of flag AND enable over bits 0–1 when `mode_i2c`=0, and over bits 2–3 when `mode_i2c`=1. It is high in the same cycle in which the flag first reads 1.
- R8: Writing address 1 clears each flag whose data bit is 1, and a 0 bit leaves that flag as it is. If a set event and a clear reach the same flag in one cycle, the flag stays set.
- R9: Writing address 2 stores data bits [2:0] as the status code, including 7, and the value reads back unchanged. A valid `op_done` code in the same cycle takes priority over the write.
- R10: Events of the inactive mode have no effect on the other mode's causes. `rx_load` with `mode_i2c`=1 does not set bit 0. `op_done` with `mode_i2c`=0 does not set bit 2 and does not change the status code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i2c | input | 1 | 1 selects I2C master causes, 0 selects SPI master causes |
| rx_load | input | 1 | Strobe: received byte written into the receive buffer |
| rx_read | input | 1 | Strobe: CPU read of the receive buffer |
| op_done | input | 1 | Strobe: I2C operation finished |
| op_code | input | 3 | Cause code that accompanies `op_done` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Interrupt request to the interrupt controller |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is a flag-setting event and a write-one-to-clear of that same flag. The second pair is an `op_done` carrying a valid code and a CPU write to the status register. The bench drives both members of each pair on the same clock edge and then reads the register back. The flag must still read 1, and the status must hold the event's code rather than the written value. A third collision, `rx_load` and `rx_read` together on an occupied buffer, is judged by the absence of the error flag.

// File: rtl/sm_irq_pkg.sv
package sm_irq_pkg;
  localparam int NCAUSE = 4;
  localparam int CODE_W = 3;

  // cause bit positions, shared by the enable and flag registers
  localparam int B_SPI_FULL = 0;
  localparam int B_SPI_ERR  = 1;
  localparam int B_I2C_DONE = 2;
  localparam int B_I2C_ERR  = 3;

  localparam logic [1:0] A_EN   = 2'd0;
  localparam logic [1:0] A_FLAG = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam logic [CODE_W-1:0] CODE_RSVD = '1;

  typedef logic [NCAUSE-1:0] cause_vec_t;

  // a new byte over unread data, unless it is read out in the same cycle
  function automatic logic is_overrun(input logic load, input logic occ, input logic rd);
    return load & occ & ~rd;
  endfunction

  // causes that may request an interrupt in the given mode
  function automatic cause_vec_t mode_mask(input logic i2c);
    cause_vec_t m;
    m = '0;
    if (i2c) begin
      m[B_I2C_DONE] = 1'b1;
      m[B_I2C_ERR]  = 1'b1;
    end else begin
      m[B_SPI_FULL] = 1'b1;
      m[B_SPI_ERR]  = 1'b1;
    end
    return m;
  endfunction

  function automatic logic req_of(input cause_vec_t fl, input cause_vec_t en, input cause_vec_t mask);
    return |(fl & en & mask);
  endfunction
endpackage

// File: rtl/rx_occupancy.sv
module rx_occupancy (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic rd,
  output logic occ,
  output logic overrun
);
  import sm_irq_pkg::*;

  assign overrun = is_overrun(load, occ, rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    occ <= 1'b0;
    else if (load) occ <= 1'b1;
    else if (rd)   occ <= 1'b0;
  end

  // R4: a read without a load empties the buffer
  p_read_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !load) |=> !occ);
  // R3: an overrun leaves fresh data in the buffer
  p_overrun_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> occ);
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R8: set beats a clear in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    // R8: a clear alone empties the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
    // R8: without a set or clear the flag holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !set[i]) |=> $stable(q[i]));
  end
endmodule

// File: rtl/status_reg.sv
module status_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic [W-1:0] ev_code,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RSVD = '1;

  logic ev_valid;
  assign ev_valid = ev && (ev_code != RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (ev_valid) q <= ev_code;
    else if (wr)       q <= wdata;
  end

  // R5/R9: a valid event code lands, ahead of any write
  p_code_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> (q == $past(ev_code)));
  // R6: a reserved event code alone leaves the status untouched
  p_no_rsvd_from_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !ev_valid && !wr) |=> $stable(q));
endmodule

// File: rtl/sm_irq_unit.sv
module sm_irq_unit #(
  parameter int CODE_W = sm_irq_pkg::CODE_W,
  parameter int ADDR_W = 2,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i2c,
  input  logic              rx_load,
  input  logic              rx_read,
  input  logic              op_done,
  input  logic [CODE_W-1:0] op_code,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  import sm_irq_pkg::*;

  localparam int NC = NCAUSE;

  cause_vec_t        en_q, flag_q, flag_set, flag_clr;
  logic [CODE_W-1:0] stat_q;
  logic              occ, overrun, stat_ev;
  logic              wr_en, wr_flag, wr_stat;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^reg_wdata[REG_W-1:NC];

  assign wr_en   = reg_wr && (reg_addr == ADDR_W'(A_EN));
  assign wr_flag = reg_wr && (reg_addr == ADDR_W'(A_FLAG));
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));

  rx_occupancy u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rx_load),
    .rd      (rx_read),
    .occ     (occ),
    .overrun (overrun)
  );

  // named per-cause events
  always_comb begin
    flag_set             = '0;
    flag_set[B_SPI_FULL] = rx_load & ~mode_i2c;
    flag_set[B_SPI_ERR]  = overrun & ~mode_i2c;
    flag_set[B_I2C_DONE] = op_done &  mode_i2c;
    flag_set[B_I2C_ERR]  = overrun &  mode_i2c;
  end
  assign flag_clr = wr_flag ? reg_wdata[NC-1:0] : '0;
  assign stat_ev  = op_done & mode_i2c;

  flag_bank #(.N(NC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  status_reg #(.W(CODE_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (stat_ev),
    .ev_code (op_code),
    .wr      (wr_stat),
    .wdata   (reg_wdata[CODE_W-1:0]),
    .q       (stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= reg_wdata[NC-1:0];
  end

  assign irq = req_of(flag_q, en_q, mode_mask(mode_i2c));

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_EN):   reg_rdata = REG_W'(en_q);
      ADDR_W'(A_FLAG): reg_rdata = REG_W'(flag_q);
      ADDR_W'(A_STAT): reg_rdata = REG_W'(stat_q);
      default:         reg_rdata = '0;
    endcase
  end

  // R7: a request always has an enabled flag behind it
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(en_q & flag_q));
  // R2: SPI load raises the buffer-full flag
  p_spi_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && !mode_i2c) |=> flag_q[B_SPI_FULL]);
  // R10: an op_done outside I2C mode leaves the status alone
  p_spi_keeps_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !mode_i2c && !wr_stat) |=> $stable(stat_q));
endmodule

// File: tb/sm_irq_unit_tb.sv
module sm_irq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       mode_i2c = 0, rx_load = 0, rx_read = 0, op_done = 0;
  logic [2:0] op_code = 0;
  logic       reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  sm_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i2c(mode_i2c), .rx_load(rx_load),
    .rx_read(rx_read), .op_done(op_done), .op_code(op_code), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus, applied at a falling edge, removed at the next
  task automatic cyc(input bit wr, input logic [1:0] a, input logic [7:0] d,
                     input bit ld, input bit rd, input bit dn, input logic [2:0] cd);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    rx_load = ld; rx_read = rd; op_done = dn; op_code = cd;
    @(negedge clk);
    reg_wr = 0; rx_load = 0; rx_read = 0; op_done = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output int v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    cyc(1, a, d, 0, 0, 0, 0);
  endtask

  task automatic clean();
    cyc(0, 0, 0, 0, 1, 0, 0);   // empty the buffer
    wr_reg(1, 8'h0F);           // clear all flags
  endtask

  task automatic t_reset();
    int v;
    rd_reg(0, v); chk("R1 enables", v, 0);
    rd_reg(1, v); chk("R1 flags", v, 0);
    rd_reg(2, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_spi_full();
    int v;
    mode_i2c = 0; clean();
    cyc(0, 0, 0, 1, 0, 0, 0);
    rd_reg(1, v); chk("R2 full flag", v, 1);
    chk("R7 no irq while disabled", irq, 0);
    wr_reg(1, 8'h00);
    rd_reg(1, v); chk("R8 write 0 no effect", v, 1);
    wr_reg(1, 8'h01);
    rd_reg(1, v); chk("R8 write 1 clears", v, 0);
  endtask

  task automatic t_overrun();
    int v;
    mode_i2c = 0; clean();
    cyc(0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    rd_reg(1, v); chk("R3 SPI overrun", v, 3);
    wr_reg(1, 8'h0F);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    rd_reg(1, v); chk("R4 load after read", v, 1);
    wr_reg(1, 8'h0F);
    cyc(0, 0, 0, 1, 1, 0, 0);     // buffer occupied, read+load together
    rd_reg(1, v); chk("R4 read with load", v, 1);
  endtask

  task automatic t_irq();
    int v;
    mode_i2c = 0; clean();
    wr_reg(0, 8'h01);
    rd_reg(0, v); chk("R7 enable readback", v, 1);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R7 irq same cycle as flag", irq, 1);
    mode_i2c = 1; #1;
    chk("R7 irq masked by mode", irq, 0);
    mode_i2c = 0; #1;
    cyc(1, 1, 8'h01, 1, 1, 0, 0); // set and clear bit 0 together
    rd_reg(1, v); chk("R8 set wins", v, 1);
    wr_reg(0, 8'h00);
    chk("R7 irq off with enable", irq, 0);
  endtask

  task automatic t_i2c_codes();
    int v;
    mode_i2c = 1; clean();
    for (int c = 0; c < 7; c++) begin
      wr_reg(1, 8'h04);
      cyc(0, 0, 0, 0, 0, 1, 3'(c));
      rd_reg(2, v); chk("R5 status code", v, c);
      rd_reg(1, v); chk("R5 done flag", v, 4);
    end
    wr_reg(1, 8'h04);
    cyc(0, 0, 0, 0, 0, 1, 3'd7);
    rd_reg(2, v); chk("R6 reserved keeps status", v, 6);
    rd_reg(1, v); chk("R6 reserved sets flag", v, 4);
    wr_reg(0, 8'h04);
    chk("R7 I2C irq", irq, 1);
    wr_reg(0, 8'h00);
  endtask

  task automatic t_i2c_overrun();
    int v;
    mode_i2c = 1; clean();
    cyc(0, 0, 0, 1, 0, 0, 0);
    rd_reg(1, v); chk("R10 no SPI full in I2C", v, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    rd_reg(1, v); chk("R3 I2C overrun", v, 8);
  endtask

  task automatic t_inactive();
    int v;
    mode_i2c = 1; wr_reg(2, 8'h02);
    mode_i2c = 0; clean();
    cyc(0, 0, 0, 0, 0, 1, 3'd5);
    rd_reg(1, v); chk("R10 no done flag in SPI", v, 1 & 0);
    rd_reg(2, v); chk("R10 status unchanged", v, 2);
  endtask

  task automatic t_status_write();
    int v;
    wr_reg(2, 8'h07);
    rd_reg(2, v); chk("R9 reserved write readback", v, 7);
    mode_i2c = 1;
    cyc(1, 2, 8'h03, 0, 0, 1, 3'd1);
    rd_reg(2, v); chk("R9 event beats write", v, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    t_reset();
    rst_n = 1;
    t_spi_full();
    t_overrun();
    t_irq();
    t_i2c_codes();
    t_i2c_overrun();
    t_inactive();
    t_status_write();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule